// File: doc/BRIEF.md
# Stack Pointer Bounds Monitor

This block watches the stack pointer of each of two CPU cores and flags a violation when the sampled value leaves a window set by software. Every core has its own register set: a lower and an upper bound, a monitor-enable mask, a separate interrupt-release mask, a self-clearing clear register, a read-only raw status register, a record-control register and a read-only captured program counter. All cores feed one shared interrupt line.

Two masks act at two different points. The monitor-enable mask gates each comparator result into the raw status, so software can poll for a violation without ever raising an interrupt. The release mask gates raw status into a registered per-condition state, and the interrupt is the OR of all those state bits. The state is not sticky: it reloads from raw AND release on every clock, and a clear write zeroes it for one cycle without touching raw status.

Samples arrive per core on a stream that carries a stack pointer and a program counter, qualified by a valid strobe. The monitor never stalls: it has no ready output, every beat with valid high is taken in the cycle it is presented, and the last taken beat is held until the next one. The register bus is a plain single-cycle write port plus an independent combinational read port.

Top module: `spbm_top`

## Requirements
- R1: After reset, for every core: enable mask 0, release mask 0, lower bound 0x00000000, upper bound 0xFFFFFFFF, record control 0b11, captured PC 0, and the interrupt is low.
- R2: Raw bit 0 (lower) is set when the held stack pointer is strictly below the lower bound, and raw bit 1 (upper) when it is strictly above the upper bound, both as 32-bit unsigned values; a value equal to a bound is no violation.
- R3: The raw status register (index 3) equals the comparator results ANDed with the enable mask (index 0, bits [1:0]); it can be set with no interrupt raised.
- R4: A sample beat with valid high is held from the next clock edge; while valid is low the held stack pointer and PC do not change.
- R5: On every clock each state bit loads raw AND release mask (index 1, bits [1:0]); reset forces it to 0.
- R6: Writing 1 to a bit of the clear register (index 2) forces that state bit to 0 at the edge of the write, over the load; the clear register reads 0 and raw status is unaffected.
- R7: The interrupt output is the OR of all state bits of all cores.
- R8: Address bit 3 selects the core and bits [2:0] the register: 0 enable, 1 release, 2 clear, 3 raw, 4 lower bound, 5 upper bound, 6 captured PC, 7 record control; cores do not affect each other.
- R9: When record control (index 7) has bit 0 (capture) and bit 1 (record) both set and any raw bit rises from 0 to 1, the captured PC loads the held PC; otherwise it holds.
- R10: Writes to the raw status and captured PC indices have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_valid | input | 2 | Per-core sample valid |
| smp_sp | input | 64 | Per-core stack pointer, core c in bits [32c+31:32c] |
| smp_pc | input | 64 | Per-core program counter, same packing |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address {core, index} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address {core, index} |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check that a state bit follows raw AND release one clock later, that a clear bit wins over the load, that the interrupt only rises from a released raw condition, and that the captured PC stays put unless recording is on and a raw bit rises. Only the bench's scenarios show the bound comparisons at their exact edges, the reset values, core isolation by address, the ignored writes to read-only registers and that a clear leaves raw status alone; its reference model compares every readable register and the interrupt on every clock.

// File: rtl/spbm_pkg.sv
package spbm_pkg;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned NCOND  = 2;
  localparam int unsigned C_LOW  = 0;
  localparam int unsigned C_HIGH = 1;

  typedef enum logic [IDX_W-1:0] {
    RG_ENA  = 3'd0,
    RG_RLS  = 3'd1,
    RG_CLR  = 3'd2,
    RG_RAW  = 3'd3,
    RG_LOW  = 3'd4,
    RG_HIGH = 3'd5,
    RG_PC   = 3'd6,
    RG_REC  = 3'd7
  } reg_idx_e;

  typedef logic [NCOND-1:0] cond_t;
endpackage

// File: rtl/spbm_sample.sv
module spbm_sample #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] pc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_o <= '0;
      pc_o <= '0;
    end else if (vld_i) begin
      sp_o <= sp_i;
      pc_o <= pc_i;
    end
  end
endmodule

// File: rtl/spbm_regs.sv
module spbm_regs
  import spbm_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  input  cond_t            raw_i,
  input  cond_t            rise_i,
  input  logic [DW-1:0]    pc_hold_i,
  output cond_t            ena_o,
  output cond_t            rls_o,
  output cond_t            clr_o,
  output logic [DW-1:0]    low_o,
  output logic [DW-1:0]    high_o
);
  localparam logic [DW-1:0] HIGH_RST = '1;
  localparam logic [1:0]    REC_RST  = 2'b11;

  logic [1:0]    rec_q;
  logic [DW-1:0] pc_cap_q;
  logic          cap_en;

  always_comb cap_en = (rec_q == 2'b11) && (|rise_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_o  <= '0;
      rls_o  <= '0;
      low_o  <= '0;
      high_o <= HIGH_RST;
      rec_q  <= REC_RST;
    end else if (wr_i) begin
      case (reg_idx_e'(wr_idx_i))
        RG_ENA:  ena_o  <= wr_data_i[NCOND-1:0];
        RG_RLS:  rls_o  <= wr_data_i[NCOND-1:0];
        RG_LOW:  low_o  <= wr_data_i;
        RG_HIGH: high_o <= wr_data_i;
        RG_REC:  rec_q  <= wr_data_i[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_cap_q <= '0;
    else if (cap_en) pc_cap_q <= pc_hold_i;
  end

  always_comb begin
    clr_o = '0;
    if (wr_i && reg_idx_e'(wr_idx_i) == RG_CLR) clr_o = wr_data_i[NCOND-1:0];
  end

  always_comb begin
    rd_data_o = '0;
    case (reg_idx_e'(rd_idx_i))
      RG_ENA:  rd_data_o[NCOND-1:0] = ena_o;
      RG_RLS:  rd_data_o[NCOND-1:0] = rls_o;
      RG_RAW:  rd_data_o[NCOND-1:0] = raw_i;
      RG_LOW:  rd_data_o = low_o;
      RG_HIGH: rd_data_o = high_o;
      RG_PC:   rd_data_o = pc_cap_q;
      RG_REC:  rd_data_o[1:0] = rec_q;
      default: rd_data_o = '0;
    endcase
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !((rec_q == 2'b11) && (|rise_i)) |=> $stable(pc_cap_q)); // R9
endmodule

// File: rtl/spbm_cond.sv
module spbm_cond
  import spbm_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] low_i,
  input  logic [DW-1:0] high_i,
  input  cond_t         ena_i,
  input  cond_t         rls_i,
  input  cond_t         clr_i,
  output cond_t         raw_o,
  output cond_t         rise_o,
  output cond_t         st_o
);
  cond_t hit;
  cond_t raw_q;

  always_comb begin
    hit         = '0;
    hit[C_LOW]  = sp_i < low_i;
    hit[C_HIGH] = sp_i > high_i;
    raw_o       = hit & ena_i;
    rise_o      = raw_o & ~raw_q;
  end

  for (genvar b = 0; b < NCOND; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_o[b]  <= 1'b0;
        raw_q[b] <= 1'b0;
      end else begin
        raw_q[b] <= raw_o[b];
        if (clr_i[b]) st_o[b] <= 1'b0;
        else          st_o[b] <= raw_o[b] & rls_i[b];
      end
    end

    AST_STATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_o[b] && rls_i[b] && !clr_i[b]) |=> st_o[b]); // R5
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[b] |=> !st_o[b]); // R6
    AST_STATE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_o[b]) |-> $past(raw_o[b] && rls_i[b])); // R5
  end
endmodule

// File: rtl/spbm_top.sv
module spbm_top
  import spbm_pkg::*;
#(
  parameter int unsigned CORES = 2,
  parameter int unsigned DW    = 32,
  localparam int unsigned CSEL_W = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int unsigned AW     = CSEL_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CORES-1:0]    smp_valid,
  input  logic [CORES*DW-1:0] smp_sp,
  input  logic [CORES*DW-1:0] smp_pc,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  output logic                irq
);
  logic [CSEL_W-1:0] wr_core, rd_core;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DW-1:0]     core_rd [CORES];
  cond_t             core_st [CORES];
  cond_t             core_rel [CORES];

  always_comb begin
    wr_core = wr_addr[AW-1:IDX_W];
    wr_idx  = wr_addr[IDX_W-1:0];
    rd_core = rd_addr[AW-1:IDX_W];
    rd_idx  = rd_addr[IDX_W-1:0];
  end

  for (genvar c = 0; c < CORES; c++) begin : g_core
    logic [DW-1:0] sp_h, pc_h, low, high;
    cond_t ena, rls, clr, raw, rise, st;
    logic  wsel;

    always_comb wsel = wr_en && (wr_core == CSEL_W'(c));

    spbm_sample #(.DW(DW)) u_smp (
      .clk(clk), .rst_n(rst_n), .vld_i(smp_valid[c]),
      .sp_i(smp_sp[c*DW +: DW]), .pc_i(smp_pc[c*DW +: DW]),
      .sp_o(sp_h), .pc_o(pc_h));

    spbm_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(wsel), .wr_idx_i(wr_idx),
      .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(core_rd[c]),
      .raw_i(raw), .rise_i(rise), .pc_hold_i(pc_h),
      .ena_o(ena), .rls_o(rls), .clr_o(clr), .low_o(low), .high_o(high));

    spbm_cond #(.DW(DW)) u_cond (
      .clk(clk), .rst_n(rst_n), .sp_i(sp_h), .low_i(low), .high_i(high),
      .ena_i(ena), .rls_i(rls), .clr_i(clr),
      .raw_o(raw), .rise_o(rise), .st_o(st));

    always_comb begin
      core_st[c]  = st;
      core_rel[c] = raw & rls;
    end
  end

  logic any_rel;
  always_comb begin
    irq     = 1'b0;
    any_rel = 1'b0;
    rd_data = '0;
    for (int c = 0; c < CORES; c++) begin
      irq     = irq | (|core_st[c]);
      any_rel = any_rel | (|core_rel[c]);
      if (rd_core == CSEL_W'(c)) rd_data = core_rd[c];
    end
  end

  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_rel)); // R7
endmodule

// File: tb/spbm_top_test.sv
`timescale 1ns/1ps
module spbm_top_test;
  localparam int DW = 32;
  logic clk = 0, rst_n = 0;
  logic [1:0]    smp_valid = 0;
  logic [63:0]   smp_sp = 0, smp_pc = 0;
  logic          wr_en = 0;
  logic [3:0]    wr_addr = 0, rd_addr = 0;
  logic [31:0]   wr_data = 0;
  logic [31:0]   rd_data;
  logic          irq;

  int checks = 0, errors = 0;
  bit done = 0;

  spbm_top uut (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sp(smp_sp),
    .smp_pc(smp_pc), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #10 clk = ~clk;

  // reference model state
  logic [1:0]  m_ena[2], m_rls[2], m_st[2], m_rawq[2], m_rec[2];
  logic [31:0] m_low[2], m_high[2], m_sp[2], m_pc[2], m_cap[2];

  function automatic logic [1:0] m_raw(int c);
    logic [1:0] r;
    r[0] = m_sp[c] < m_low[c];
    r[1] = m_sp[c] > m_high[c];
    return r & m_ena[c];
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    int c = a[3];
    case (a[2:0])
      3'd0: return {30'd0, m_ena[c]};
      3'd1: return {30'd0, m_rls[c]};
      3'd3: return {30'd0, m_raw(c)};
      3'd4: return m_low[c];
      3'd5: return m_high[c];
      3'd6: return m_cap[c];
      3'd7: return {30'd0, m_rec[c]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(logic [2:0] i);
    case (i)
      3'd0, 3'd1: return "R8";
      3'd2: return "R6";
      3'd3: return "R3";
      3'd4, 3'd5: return "R2";
      3'd6: return "R9";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_ena[c] = 0; m_rls[c] = 0; m_st[c] = 0; m_rawq[c] = 0; m_rec[c] = 2'b11; // R1
        m_low[c] = 0; m_high[c] = 32'hFFFF_FFFF; m_sp[c] = 0; m_pc[c] = 0; m_cap[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        logic [1:0] r, clrv;
        r = m_raw(c);
        clrv = (wr_en && wr_addr[3] == c && wr_addr[2:0] == 3'd2) ? wr_data[1:0] : 2'b00;
        if ((r & ~m_rawq[c]) != 0 && m_rec[c] == 2'b11) m_cap[c] = m_pc[c]; // R9
        m_st[c]   = r & m_rls[c] & ~clrv; // R5 R6
        m_rawq[c] = r;
        if (wr_en && wr_addr[3] == c) begin
          case (wr_addr[2:0])
            3'd0: m_ena[c]  = wr_data[1:0];
            3'd1: m_rls[c]  = wr_data[1:0];
            3'd4: m_low[c]  = wr_data;
            3'd5: m_high[c] = wr_data;
            3'd7: m_rec[c]  = wr_data[1:0];
            default: ; // R10 raw and PC writes ignored
          endcase
        end
        if (smp_valid[c]) begin // R4
          m_sp[c] = smp_sp[c*DW +: DW];
          m_pc[c] = smp_pc[c*DW +: DW];
        end
      end
    end
  end

  // compare every readable register and irq away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== ((|m_st[0]) | (|m_st[1]))) begin
        errors++;
        $display("FAIL R7 irq actual %0b expected %0b at %0t", irq, (|m_st[0]) | (|m_st[1]), $time);
      end
      for (int a = 0; a < 16; a++) begin
        rd_addr = 4'(a);
        #0.4;
        checks++;
        if (rd_data !== m_read(4'(a))) begin
          errors++;
          $display("FAIL %s/R10 addr %0d actual %h expected %h at %0t",
                   tag(3'(a)), a, rd_data, m_read(4'(a)), $time);
        end
      end
    end
  end

  task automatic wr(input int c, input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = {1'(c), 3'(idx)}; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic smp(input int c, input logic [31:0] sp, input logic [31:0] pc);
    @(negedge clk);
    smp_valid[c] = 1; smp_sp[c*DW +: DW] = sp; smp_pc[c*DW +: DW] = pc;
    @(negedge clk);
    smp_valid[c] = 0;
    smp_sp[c*DW +: DW] = 32'hDEAD_0000; // R4 ignored while valid low
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);                              // R1 reset state
    wr(0, 5, 32'h0000_1000);
    wr(0, 0, 32'h3);
    smp(0, 32'h0000_1000, 32'h10);        // R2 equal to upper: no hit
    idle(2);
    smp(0, 32'h0000_1001, 32'hA0);        // R2 R3 R9 raw without irq, PC captured
    idle(3);
    wr(0, 1, 32'h2);                      // R5 release -> irq
    idle(3);
    wr(0, 2, 32'h2);                      // R6 one-cycle clear, raw kept
    idle(3);
    wr(0, 3, 32'h0);                      // R10
    wr(0, 6, 32'h1234_5678);              // R10
    smp(0, 32'h0000_0800, 32'hB0);
    idle(2);
    wr(0, 4, 32'h0000_0800);              // R2 equal to lower: no hit
    smp(0, 32'h0000_07FF, 32'hC0);        // R2 lower hit, not released
    idle(2);
    wr(0, 1, 32'h3);
    idle(2);
    wr(0, 7, 32'h1);                      // R9 capture off
    smp(0, 32'h0000_2000, 32'hD0);
    idle(2);
    wr(1, 0, 32'h2);                      // R8 core 1
    wr(1, 5, 32'h10);
    wr(1, 1, 32'h2);
    smp(1, 32'h20, 32'hE0);
    idle(2);
    wr(0, 2, 32'h3);                      // R7 core 1 still drives irq
    wr(0, 0, 32'h0);
    idle(3);
    wr(1, 2, 32'h2);
    wr(1, 1, 32'h0);
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule